// File: doc/BRIEF.md
# Radix Page Tree Walker

This block translates one address at a time by walking a tree of 64-bit directory entries held in memory. The caller gives the address to translate and a root descriptor word. The descriptor carries the root directory base, the index width of the root level and an encoded total address size. At each level the walker forms the address of the entry, fetches it over a request/acknowledge/response port and decides whether to go one level deeper. It stops when it reaches a leaf and reports the real address, the final page size and the leaf entry. If the walk cannot finish, it reports a fault cause instead.

The index width of every level after the root comes from the directory entry that points to it. The walker checks that width against a fixed set of legal tree shapes before it reads that level, so a tree that is built wrongly stops early and does no stray memory reads. Only one walk runs at a time. A request that arrives while a walk is running is dropped.

Top module: `ptw_radix`

## Requirements
- R1: The root descriptor is decoded as follows. The base is bits 59:8 and the root index width is bits 4:0. The total size is ((bits 62:61) << 3 | bits 7:5) + 31. A root whose total size is not 52, or whose index width is not 13, ends with fault cause 2 and issues no memory read.
- R2: At every level, index = (address >> (remaining size − width)) masked to width bits. The entry address is the aligned base plus index × 8. The remaining size starts at the total size and drops by the width of a level once that level's entry is read.
- R3: If a directory base is not aligned to 2^(width+3), its low bits are cleared and the walk continues with no fault.
- R4: The memory request is held high with a stable address until it is acknowledged. At most one read is outstanding, and the response is taken on the cycle its valid is high.
- R5: A fetched entry whose valid flag (bit 63) is clear ends the walk with fault cause 1 (no entry).
- R6: A directory entry (bit 63 set, leaf flag bit 62 clear) supplies the next base from bits 59:8 and the next width from bits 4:0. Levels 1 and 2 need width 9. Level 3 accepts width 9 or 5. A fourth directory level is illegal. A violation ends the walk with fault cause 2 before that level is read.
- R7: On a leaf (bits 63 and 62 set) the real address is the leaf's bits 56:12 with every bit below the remaining size cleared, ORed with those low bits of the address. The page size output equals the remaining size, and the leaf word is output unchanged. Fault cause 0 means no fault.
- R8: Completion is a one-cycle done pulse. req_ready is high only while idle, and a request presented while a walk is running is ignored.
- R9: After reset, req_ready is high and both mem_req_valid and done_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when req_ready) |
| req_ready | output | 1 | Walker is idle |
| req_vaddr | input | 64 | Address to translate |
| req_root | input | 64 | Root descriptor word |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 64 | Entry address, 8-byte aligned |
| mem_req_ack | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry word read |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| res_raddr | output | 64 | Translated real address |
| res_page_size | output | 7 | Log2 of the final page size |
| res_pte | output | 64 | Leaf entry word |

## Verification
The assertions watch the port protocol on every cycle. They check that a pending request stays held and stable, that entry addresses are 8-byte aligned, that the done pulse lasts one cycle, that the fault flag agrees with the cause code, and that no read is issued beyond the deepest legal level. The bench scenarios are what show the arithmetic. They use a memory image that holds leaves at every depth, a misaligned base with a decoy entry at the unaligned address, illegal widths, a missing entry, and bad root descriptors. For each one the bench checks the translated address, the page size, the cause code, the number of reads and the exact sequence of entry addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int WORD_W    = 64;
  localparam int WIDTH_W   = 5;
  localparam int SIZE_W    = 7;
  localparam int SIZE_BIAS = 31;

  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;

  localparam logic [WORD_W-1:0] BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [WORD_W-1:0] RPN_MASK  = 64'h01FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NO_ENTRY = 2'd1,
    CAUSE_BAD_CFG  = 2'd2
  } ptw_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_DONE,
    ST_FAULT
  } ptw_state_e;

  function automatic logic [SIZE_W-1:0] root_total_size(input logic [WORD_W-1:0] w);
    logic [4:0] enc;
    enc = {w[62:61], w[7:5]};
    return SIZE_W'(enc) + SIZE_W'(SIZE_BIAS);
  endfunction

endpackage

// File: rtl/ptw_index.sv
module ptw_index
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0]  base,
  input  logic [WIDTH_W-1:0] width,
  input  logic [SIZE_W-1:0]  remaining,
  input  logic [WORD_W-1:0]  vaddr,
  output logic [WORD_W-1:0]  entry_addr
);
  logic [SIZE_W-1:0] shift_amt;
  logic [SIZE_W-1:0] align_bits;
  logic [WORD_W-1:0] idx_mask;
  logic [WORD_W-1:0] align_mask;
  logic [WORD_W-1:0] idx;

  always_comb begin
    shift_amt  = remaining - SIZE_W'(width);
    align_bits = SIZE_W'(width) + SIZE_W'(3);
    idx_mask   = (64'd1 << width) - 64'd1;
    align_mask = (64'd1 << align_bits) - 64'd1;
    idx        = (vaddr >> shift_amt) & idx_mask;
    entry_addr = (base & ~align_mask) + (idx << 3);
  end
endmodule

// File: rtl/ptw_lvl_check.sv
module ptw_lvl_check
  import ptw_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5,
  localparam int LVL_W    = $clog2(MAX_DEPTH + 1)
)(
  input  logic [LVL_W-1:0]   level,
  input  logic [SIZE_W-1:0]  remaining,
  input  logic [WIDTH_W-1:0] width,
  output logic               legal
);
  always_comb begin
    if (level == '0)
      legal = (remaining == SIZE_W'(ROOT_SIZE)) && (width == WIDTH_W'(ROOT_NLS));
    else if (int'(level) < MAX_DEPTH - 1)
      legal = (width == WIDTH_W'(MID_NLS));
    else if (int'(level) == MAX_DEPTH - 1)
      legal = (width == WIDTH_W'(MID_NLS)) || (width == WIDTH_W'(ALT_NLS));
    else
      legal = 1'b0;
  end
endmodule

// File: rtl/ptw_leaf_addr.sv
module ptw_leaf_addr
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] pte,
  input  logic [WORD_W-1:0] vaddr,
  input  logic [SIZE_W-1:0] remaining,
  output logic [WORD_W-1:0] raddr
);
  logic [WORD_W-1:0] low_mask;
  always_comb begin
    low_mask = (64'd1 << remaining) - 64'd1;
    raddr    = ((pte & RPN_MASK) & ~low_mask) | (vaddr & low_mask);
  end
endmodule

// File: rtl/ptw_radix.sv
module ptw_radix
  import ptw_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_NLS  = 13,
  parameter int MID_NLS   = 9,
  parameter int ALT_NLS   = 5
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [63:0] req_root,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_req_ack,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done_valid,
  output logic        done_fault,
  output logic [1:0]  fault_cause,
  output logic [63:0] res_raddr,
  output logic [6:0]  res_page_size,
  output logic [63:0] res_pte
);
  localparam int LVL_W = $clog2(MAX_DEPTH + 1);

  ptw_state_e          state_q;
  logic [WORD_W-1:0]   va_q;
  logic [WORD_W-1:0]   base_q;
  logic [WIDTH_W-1:0]  width_q;
  logic [SIZE_W-1:0]   rem_q;
  logic [LVL_W-1:0]    lvl_q;

  logic [WORD_W-1:0]   entry_addr;
  logic                lvl_legal;
  logic [SIZE_W-1:0]   rem_next;
  logic [WORD_W-1:0]   leaf_raddr;

  assign rem_next  = rem_q - SIZE_W'(width_q);
  assign req_ready = (state_q == ST_IDLE);

  ptw_index u_index (
    .base       (base_q),
    .width      (width_q),
    .remaining  (rem_q),
    .vaddr      (va_q),
    .entry_addr (entry_addr)
  );

  ptw_lvl_check #(
    .MAX_DEPTH (MAX_DEPTH),
    .ROOT_SIZE (ROOT_SIZE),
    .ROOT_NLS  (ROOT_NLS),
    .MID_NLS   (MID_NLS),
    .ALT_NLS   (ALT_NLS)
  ) u_lvl_check (
    .level     (lvl_q),
    .remaining (rem_q),
    .width     (width_q),
    .legal     (lvl_legal)
  );

  ptw_leaf_addr u_leaf (
    .pte       (mem_rsp_data),
    .vaddr     (va_q),
    .remaining (rem_next),
    .raddr     (leaf_raddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      va_q          <= '0;
      base_q        <= '0;
      width_q       <= '0;
      rem_q         <= '0;
      lvl_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done_valid    <= 1'b0;
      done_fault    <= 1'b0;
      fault_cause   <= CAUSE_NONE;
      res_raddr     <= '0;
      res_page_size <= '0;
      res_pte       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            base_q  <= req_root & BASE_MASK;
            width_q <= req_root[WIDTH_W-1:0];
            rem_q   <= root_total_size(req_root);
            lvl_q   <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (lvl_legal) begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= entry_addr;
            state_q       <= ST_READ_REQ;
          end else begin
            done_valid  <= 1'b1;
            done_fault  <= 1'b1;
            fault_cause <= CAUSE_BAD_CFG;
            state_q     <= ST_FAULT;
          end
        end
        ST_READ_REQ: begin
          if (mem_req_ack) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_READ_WAIT;
          end
        end
        ST_READ_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[VALID_BIT]) begin
              done_valid  <= 1'b1;
              done_fault  <= 1'b1;
              fault_cause <= CAUSE_NO_ENTRY;
              state_q     <= ST_FAULT;
            end else if (mem_rsp_data[LEAF_BIT]) begin
              done_valid    <= 1'b1;
              done_fault    <= 1'b0;
              fault_cause   <= CAUSE_NONE;
              res_raddr     <= leaf_raddr;
              res_page_size <= rem_next;
              res_pte       <= mem_rsp_data;
              state_q       <= ST_DONE;
            end else begin
              base_q  <= mem_rsp_data & BASE_MASK;
              width_q <= mem_rsp_data[WIDTH_W-1:0];
              rem_q   <= rem_next;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= ST_CHECK;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          done_valid <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Protocol checks
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ack) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_entry_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_busy_no_ready_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_cause_flag_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_fault == (fault_cause != 2'd0)));

  assert_depth_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ_REQ) |-> (int'(lvl_q) < MAX_DEPTH));

  assert_leaf_size_R7: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault) |-> (res_page_size < 7'(ROOT_SIZE)));

endmodule

// File: tb/ptw_radix_bench.sv
module ptw_radix_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [63:0] req_root;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_req_ack;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done_valid;
  logic        done_fault;
  logic [1:0]  fault_cause;
  logic [63:0] res_raddr;
  logic [6:0]  res_page_size;
  logic [63:0] res_pte;

  always #4 clk = ~clk;

  ptw_radix u_ptw_radix (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ack(mem_req_ack), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
    .done_fault(done_fault), .fault_cause(fault_cause),
    .res_raddr(res_raddr), .res_page_size(res_page_size), .res_pte(res_pte)
  );

  // Root: total size 52 (upper 2'b10, lower 3'b101), base 0x10000, width 13
  localparam logic [63:0] ROOT_OK     = 64'h4000_0000_0001_00AD;
  localparam logic [63:0] ROOT_SIZE48 = 64'h4000_0000_0001_002D;
  localparam logic [63:0] ROOT_NLS12  = 64'h4000_0000_0001_00AC;

  localparam int NV = 10;
  localparam logic [63:0] T_VA [NV] = '{
    64'h0000_0000_0000_5123, 64'h0000_0000_0000_6777, 64'h0000_0000_0020_1234,
    64'h0000_0000_4000_0ABC, 64'h0000_0000_8000_0000, 64'h0000_0000_C003_4567,
    64'h0000_0001_0000_0089, 64'h0000_0000_0000_7000, 64'h0000_0080_0000_0000,
    64'h000F_FF80_0000_0055};
  localparam logic [63:0] T_RA [NV] = '{
    64'h0ABC_D123, 64'h0, 64'h0360_1234, 64'h8000_0ABC, 64'h0, 64'h1230_4567,
    64'h00C0_0089, 64'h0, 64'h0, 64'h0180_0000_0000_0055};
  localparam int T_SIZE  [NV] = '{12, 0, 21, 30, 0, 16, 21, 0, 0, 39};
  localparam int T_CAUSE [NV] = '{0, 1, 0, 0, 2, 0, 0, 2, 1, 0};
  localparam int T_READS [NV] = '{4, 4, 3, 2, 2, 4, 3, 4, 1, 1};

  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] addr_log [8];
  int reads;
  int dly;
  int n_run  = 0;
  int n_fail = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Memory model: variable acknowledge delay, response one cycle after ack
  initial begin
    logic [63:0] lat;
    mem_req_ack = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    dly = 0; lat = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (mem_req_ack) begin
        mem_req_ack   = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_img.exists(lat) ? mem_img[lat] : 64'h0;
      end else if (mem_req_valid) begin
        if (dly > 0) dly--;
        else begin
          mem_req_ack = 1'b1;
          lat = mem_req_addr;
          if (reads < 8) addr_log[reads] = lat;
          reads++;
          dly = reads % 3;
        end
      end
    end
  end

  task automatic run_walk(input logic [63:0] va, input logic [63:0] root);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done_valid && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    chk("R8 walk completes", 64'(guard < 300), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mem_img[64'h10000] = 64'h8000_0000_0002_0009;
    mem_img[64'h1FFF8] = 64'hC180_0000_0000_0000;
    mem_img[64'h20000] = 64'h8000_0000_0003_0009;
    mem_img[64'h20008] = 64'hC000_0000_8000_0000;
    mem_img[64'h20010] = 64'h8000_0000_0005_0005;
    mem_img[64'h20018] = 64'h8000_0000_0005_0009;
    mem_img[64'h20020] = 64'h8000_0000_0007_0109;
    mem_img[64'h30000] = 64'h8000_0000_0004_0009;
    mem_img[64'h30008] = 64'hC000_0000_0360_0000;
    mem_img[64'h40028] = 64'hC000_0000_0ABC_D103;
    mem_img[64'h40038] = 64'h8000_0000_0008_0009;
    mem_img[64'h50000] = 64'h8000_0000_0006_0005;
    mem_img[64'h60018] = 64'hC000_0000_1230_0000;
    mem_img[64'h70000] = 64'hC000_0000_00C0_0000;
    mem_img[64'h70100] = 64'hC000_0000_00E0_0000;

    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_root = '0; reads = 0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 req_ready in reset", 64'(req_ready), 64'd1);
    chk("R9 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk("R9 done_valid in reset", 64'(done_valid), 64'd0);
    rst = 1'b0;

    // Table of walks
    for (int i = 0; i < NV; i++) begin
      run_walk(T_VA[i], ROOT_OK);
      chk($sformatf("R5 R6 cause v%0d", i), 64'(fault_cause), 64'(T_CAUSE[i]));
      chk($sformatf("R5 fault flag v%0d", i), 64'(done_fault), 64'(T_CAUSE[i] != 0));
      chk($sformatf("R4 read count v%0d", i), 64'(reads), 64'(T_READS[i]));
      if (T_CAUSE[i] == 0) begin
        chk($sformatf("R7 raddr v%0d", i), res_raddr, T_RA[i]);
        chk($sformatf("R7 page size v%0d", i), 64'(res_page_size), 64'(T_SIZE[i]));
        chk($sformatf("R7 leaf word v%0d", i), res_pte, mem_img[addr_log[T_READS[i]-1]]);
      end
      if (i == 0) begin
        chk("R2 level0 addr", addr_log[0], 64'h10000);
        chk("R2 level1 addr", addr_log[1], 64'h20000);
        chk("R2 level2 addr", addr_log[2], 64'h30000);
        chk("R2 level3 addr", addr_log[3], 64'h40028);
      end
      if (i == 5) chk("R6 width5 at level3 addr", addr_log[3], 64'h60018);
      if (i == 6) chk("R3 aligned base addr", addr_log[2], 64'h70000);
      @(negedge clk);
      chk($sformatf("R8 done one cycle v%0d", i), 64'(done_valid), 64'd0);
    end

    // R1 bad root descriptors: no reads, bad configuration
    run_walk(64'h5123, ROOT_SIZE48);
    chk("R1 size48 cause", 64'(fault_cause), 64'd2);
    chk("R1 size48 no reads", 64'(reads), 64'd0);
    run_walk(64'h5123, ROOT_NLS12);
    chk("R1 width12 cause", 64'(fault_cause), 64'd2);
    chk("R1 width12 no reads", 64'(reads), 64'd0);

    // R8 request while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    reads = 0;
    req_valid = 1'b1; req_vaddr = T_VA[0]; req_root = ROOT_OK;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 not ready while busy", 64'(req_ready), 64'd0);
    req_valid = 1'b1; req_vaddr = T_VA[3]; req_root = ROOT_SIZE48;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int guard = 0;
      while (!done_valid && guard < 300) begin @(negedge clk); guard++; end
    end
    chk("R8 busy request ignored raddr", res_raddr, T_RA[0]);
    chk("R8 busy request ignored size", 64'(res_page_size), 64'd12);
    @(negedge clk);
    chk("R8 idle after walk", 64'(req_ready), 64'd1);
    chk("R8 no stray walk", 64'(mem_req_valid), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule